// File: doc/BRIEF.md
# Area-Based External Bus Controller

This block sits between a simple CPU request port and an external memory bus. Every CPU access address falls into one of eight equal address areas. The block picks the area from the top three bits of the active address width. It then runs the external bus cycle using the width, state-count and wait settings held for that area. Each area has its own active-low chip select. There is one read strobe, and there are separate write strobes for the high and low data lanes.

A request is accepted only while the bus is idle. The CPU presents a start strobe together with an address, a read/write flag, a byte/word flag and write data. When the access ends, the block pulses a done flag for one cycle. For reads, the assembled data is valid during that pulse.

Each area is configured for either an 8-bit or a 16-bit bus and for two-state or three-state cycles, with zero to three inserted wait states. A global option lets an external wait pin stretch the final programmed wait state. A second global option restricts the block to a 1-Mbyte space with 20 driven address bits.

Top module: `area_bus_ctrl`

## Requirements
- R1: The area index is `req_addr[23:21]` in the full 16-Mbyte space, and `req_addr[19:17]` when `cfg_narrow_space` is 1. In the narrow space, `bus_addr[23:20]` is driven as zero.
- R2: `bus_cs_n[k]` is low in exactly the bus states of an access to area k. All chip selects are high while the bus is idle, including the cycle in which `rsp_done` is high.
- R3: One bus cycle lasts T1, then T2, then `cfg_waits[2k+1:2k]` wait states, then a T3 state only if `cfg_three[k]` is 1. States follow each other on consecutive clocks from the cycle after the request is accepted.
- R4: For a read, `bus_rd_n` is low in every state of the bus cycle except T1. For a write, the write strobe of each used lane is low in those same states. Read and write strobes are never low together.
- R5: In a 16-bit area (`cfg_wide[k]`=1), a word access uses both lanes: `bus_dout`=`req_wdata`, and read data is taken from `bus_din[15:0]`. A byte access at an even address uses the high lane: data on `bus_dout[15:8]`, strobe `bus_wrh_n`, read from `bus_din[15:8]`. A byte access at an odd address uses the low lane: data on `bus_dout[7:0]`, strobe `bus_wrl_n`, read from `bus_din[7:0]`.
- R6: An 8-bit area uses only the high lane, and `bus_wrl_n` stays high. A word access to it becomes two back-to-back byte cycles. The first cycle is at the even address and carries `req_wdata[15:8]`. The second is at the address plus one and carries `req_wdata[7:0]`. The read result is {first byte, second byte}.
- R7: A word access ignores `req_addr[0]` and runs at the even address.
- R8: With `cfg_wait_pin`=1 and a nonzero wait count, the final programmed wait state is repeated for every clock in which `bus_wait_n` is low during it. This applies to each byte cycle of a split access.
- R9: `bus_wait_n` has no effect when `cfg_wait_pin`=0, or when the area's wait count is zero.
- R10: `rsp_done` is high for one clock, starting the clock after the last bus state. A byte read returns its byte zero-extended in `rsp_rdata[7:0]`, and a word read returns 16 bits.
- R11: A `req` pulse that arrives while an access is in progress is ignored. The ongoing access runs unchanged.
- R12: After reset, all chip selects and strobes are high, `bus_addr` and `bus_dout` are zero, `rsp_done` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start strobe, taken only while idle |
| req_addr | input | 24 | Byte address of the access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| rsp_done | output | 1 | One-clock completion pulse |
| cfg_narrow_space | input | 1 | 1 = 1-Mbyte space with 20 address bits |
| cfg_wait_pin | input | 1 | 1 = external pin may stretch the final wait state |
| cfg_wide | input | 8 | Per area: 1 = 16-bit bus |
| cfg_three | input | 8 | Per area: 1 = three-state cycle |
| cfg_waits | input | 16 | Per area k, bits [2k+1:2k]: wait-state count |
| bus_addr | output | 24 | External address, zero when idle |
| bus_cs_n | output | 8 | Active-low chip select per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wrh_n | output | 1 | Active-low write strobe, high lane |
| bus_wrl_n | output | 1 | Active-low write strobe, low lane |
| bus_dout | output | 16 | Write data lanes, zero outside writes |
| bus_din | input | 16 | Read data lanes |
| bus_wait_n | input | 1 | Active-low external wait request |

## Verification
The bench builds the block with its default parameters: a 24-bit address, three area bits and a two-bit wait count. The wait counts therefore reach both zero and the maximum of three. Across the eight areas, the bench configuration covers every pairing of bus width and state count. The narrow-space input is also toggled, so the 20-bit decode and address masking are observed alongside the full-width space. With this configuration, the bench can stretch split byte cycles by the wait pin and exercise the state-count boundaries.

// File: rtl/abc_pkg.sv
// Shared types for the area-based external bus controller.
// Assumes a 16-bit external data bus made of two byte lanes.
package abc_pkg;

    // Which external data lanes a bus cycle uses.
    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_HI   = 2'd1,
        LANE_LO   = 2'd2,
        LANE_BOTH = 2'd3
    } lane_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BUS_W  = 2 * BYTE_W;

endpackage

// File: rtl/abc_area_decode.sv
// Address decoder: selects one of 2**AREA_BITS areas from the top bits
// of the active address width, masks unused upper bits in the narrow
// space, and forces word accesses to the even address.
// Assumes NARROW_AW > AREA_BITS and NARROW_AW < ADDR_W.
module abc_area_decode #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned NARROW_AW = 20,
    parameter int unsigned AREA_BITS = 3
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 narrow,
    input  logic                 word,
    output logic [AREA_BITS-1:0] area,
    output logic [ADDR_W-1:0]    eff_addr
);

    // Area index and effective address from the raw request address.
    always_comb begin
        eff_addr = addr;
        if (narrow) begin
            eff_addr[ADDR_W-1:NARROW_AW] = '0;
        end
        if (word) begin
            eff_addr[0] = 1'b0;
        end
        area = narrow ? addr[NARROW_AW-1 -: AREA_BITS]
                      : addr[ADDR_W-1 -: AREA_BITS];
    end

endmodule

// File: rtl/abc_cycle_timer.sv
// Bus-cycle state sequencer: T1, T2, the programmed wait states, then an
// optional T3. When the pin is enabled, the final programmed wait state
// repeats while the external wait input is low.
// Assumes three/waits/pin_en stay stable while a cycle runs.
module abc_cycle_timer #(
    parameter int unsigned WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              three,
    input  logic [WAIT_W-1:0] waits,
    input  logic              pin_en,
    input  logic              wait_n,
    output logic              run,
    output logic              first,
    output logic              last
);

    localparam int unsigned CNT_W = WAIT_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] final_idx;
    logic [CNT_W-1:0] tw_idx;
    logic             stall;

    // Position of the last programmed wait state and of the final state.
    always_comb begin
        tw_idx    = CNT_W'(waits) + CNT_W'(1);
        final_idx = CNT_W'(waits) + CNT_W'(three) + CNT_W'(1);
        stall     = run && pin_en && (waits != '0) && (cnt == tw_idx) && !wait_n;
        last      = run && !stall && (cnt == final_idx);
        first     = run && (cnt == '0);
    end

    // State counter: restart on start, stop after the final state, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (last) begin
            run <= 1'b0;
        end else if (run && !stall) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= final_idx));

    p_start_gives_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> first);

    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pin_en && (waits != '0) && (cnt == tw_idx) && !wait_n && !start)
        |=> (run && $stable(cnt)));

endmodule

// File: rtl/abc_lane_mux.sv
// Byte-lane steering: picks the data lanes for the current byte or word
// cycle, places write data on them, and selects the read byte.
// Assumes an 8-bit area always uses the high lane.
module abc_lane_mux
    import abc_pkg::*;
(
    input  logic              wide,
    input  logic              word,
    input  logic              addr0,
    input  logic              second,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  din,
    output lane_e             lane,
    output logic [BUS_W-1:0]  dout,
    output logic [BYTE_W-1:0] rbyte
);

    // Lane selection and data placement for each width/size case.
    always_comb begin
        if (!wide) begin
            lane  = LANE_HI;
            dout  = {(word && !second) ? wdata[BUS_W-1:BYTE_W] : wdata[BYTE_W-1:0],
                     {BYTE_W{1'b0}}};
            rbyte = din[BUS_W-1:BYTE_W];
        end else if (word) begin
            lane  = LANE_BOTH;
            dout  = wdata;
            rbyte = din[BYTE_W-1:0];
        end else if (addr0) begin
            lane  = LANE_LO;
            dout  = {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
            rbyte = din[BYTE_W-1:0];
        end else begin
            lane  = LANE_HI;
            dout  = {wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
            rbyte = din[BUS_W-1:BYTE_W];
        end
    end

endmodule

// File: rtl/area_bus_ctrl.sv
// Area-based external bus controller (top). Latches an accepted request
// with the settings of its area, runs one or two bus cycles through the
// cycle timer, drives chip select, strobes and lanes, and returns read
// data with a one-clock done pulse.
// Assumes requests are only meaningful while idle; others are dropped.
module area_bus_ctrl
    import abc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned NARROW_AW = 20,
    parameter int unsigned AREA_BITS = 3,
    parameter int unsigned WAIT_W    = 2,
    localparam int unsigned NAREA    = 1 << AREA_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_wr,
    input  logic                    req_word,
    input  logic [15:0]             req_wdata,
    output logic [15:0]             rsp_rdata,
    output logic                    rsp_done,
    input  logic                    cfg_narrow_space,
    input  logic                    cfg_wait_pin,
    input  logic [NAREA-1:0]        cfg_wide,
    input  logic [NAREA-1:0]        cfg_three,
    input  logic [NAREA*WAIT_W-1:0] cfg_waits,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [NAREA-1:0]        bus_cs_n,
    output logic                    bus_rd_n,
    output logic                    bus_wrh_n,
    output logic                    bus_wrl_n,
    output logic [15:0]             bus_dout,
    input  logic [15:0]             bus_din,
    input  logic                    bus_wait_n
);

    logic [AREA_BITS-1:0] area_d;
    logic [ADDR_W-1:0]    eff_d;

    logic [ADDR_W-1:0]    a_q;
    logic [AREA_BITS-1:0] area_q;
    logic                 wr_q;
    logic                 word_q;
    logic [BUS_W-1:0]     wdata_q;
    logic                 wide_q;
    logic                 three_q;
    logic [WAIT_W-1:0]    waits_q;
    logic                 pin_q;
    logic                 second_q;
    logic [BYTE_W-1:0]    hi_q;
    logic [BUS_W-1:0]     rdata_q;
    logic                 done_q;

    logic                 run;
    logic                 tm_first;
    logic                 tm_last;
    logic                 accept;
    logic                 split;
    logic                 more;
    logic                 tm_start;
    logic                 strobe_on;
    lane_e                lane;
    logic [BUS_W-1:0]     lane_dout;
    logic [BYTE_W-1:0]    rbyte;
    logic [ADDR_W-1:0]    cur_addr;

    abc_area_decode #(
        .ADDR_W    (ADDR_W),
        .NARROW_AW (NARROW_AW),
        .AREA_BITS (AREA_BITS)
    ) u_decode (
        .addr     (req_addr),
        .narrow   (cfg_narrow_space),
        .word     (req_word),
        .area     (area_d),
        .eff_addr (eff_d)
    );

    // Sequencing controls: accept, split continuation and timer restart.
    always_comb begin
        accept   = req && !run;
        split    = word_q && !wide_q;
        more     = tm_last && split && !second_q;
        tm_start = accept || more;
    end

    abc_cycle_timer #(
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tm_start),
        .three  (three_q),
        .waits  (waits_q),
        .pin_en (pin_q),
        .wait_n (bus_wait_n),
        .run    (run),
        .first  (tm_first),
        .last   (tm_last)
    );

    abc_lane_mux u_lanes (
        .wide   (wide_q),
        .word   (word_q),
        .addr0  (a_q[0]),
        .second (second_q),
        .wdata  (wdata_q),
        .din    (bus_din),
        .lane   (lane),
        .dout   (lane_dout),
        .rbyte  (rbyte)
    );

    // Request latch: capture address, command and area settings on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            area_q   <= '0;
            wr_q     <= 1'b0;
            word_q   <= 1'b0;
            wdata_q  <= '0;
            wide_q   <= 1'b0;
            three_q  <= 1'b0;
            waits_q  <= '0;
            pin_q    <= 1'b0;
            second_q <= 1'b0;
        end else if (accept) begin
            a_q      <= eff_d;
            area_q   <= area_d;
            wr_q     <= req_wr;
            word_q   <= req_word;
            wdata_q  <= req_wdata;
            wide_q   <= cfg_wide[area_d];
            three_q  <= cfg_three[area_d];
            waits_q  <= cfg_waits[area_d*WAIT_W +: WAIT_W];
            pin_q    <= cfg_wait_pin;
            second_q <= 1'b0;
        end else if (more) begin
            second_q <= 1'b1;
        end
    end

    // Read capture and completion pulse at the final bus state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= tm_last && !more;
            if (tm_last && !wr_q) begin
                if (more) begin
                    hi_q <= rbyte;
                end else if (split) begin
                    rdata_q <= {hi_q, rbyte};
                end else if (word_q) begin
                    rdata_q <= bus_din;
                end else begin
                    rdata_q <= {{BYTE_W{1'b0}}, rbyte};
                end
            end
        end
    end

    // External address, strobes and data lanes from the running cycle.
    always_comb begin
        cur_addr  = a_q | ADDR_W'(second_q);
        bus_addr  = run ? cur_addr : '0;
        strobe_on = run && !tm_first;
        bus_rd_n  = !(strobe_on && !wr_q);
        bus_wrh_n = !(strobe_on && wr_q && (lane == LANE_HI || lane == LANE_BOTH));
        bus_wrl_n = !(strobe_on && wr_q && (lane == LANE_LO || lane == LANE_BOTH));
        bus_dout  = (run && wr_q) ? lane_dout : '0;
        rsp_rdata = rdata_q;
        rsp_done  = done_q;
    end

    // One chip select per area, active while that area's access runs.
    for (genvar k = 0; k < NAREA; k++) begin : g_cs
        assign bus_cs_n[k] = !(run && (area_q == AREA_BITS'(k)));
    end

    p_strobe_has_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wrh_n || !bus_wrl_n) |-> (bus_cs_n != '1));

    p_rd_wr_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && (!bus_wrh_n || !bus_wrl_n)));

    p_narrow_no_low_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wide_q) |-> bus_wrl_n);

    p_done_one_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_busy_keeps_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tm_last) |=> ($stable(a_q) && $stable(area_q) && $stable(wr_q)));

endmodule

// File: tb/area_bus_ctrl_test.sv
// Bench for area_bus_ctrl: a behavioural model expands each request into
// a queue of expected per-clock bus values, compared on every falling edge.
module area_bus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [23:0] req_addr;
    logic        req_wr;
    logic        req_word;
    logic [15:0] req_wdata;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic        cfg_narrow_space;
    logic        cfg_wait_pin;
    logic [7:0]  cfg_wide;
    logic [7:0]  cfg_three;
    logic [15:0] cfg_waits;
    logic [23:0] bus_addr;
    logic [7:0]  bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wrh_n;
    logic        bus_wrl_n;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;
    logic        bus_wait_n;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R12";

    typedef struct packed {
        logic [7:0]  cs;
        logic [23:0] a;
        logic        rd;
        logic        wh;
        logic        wl;
        logic [15:0] dout;
        logic        done;
        logic        chk_rd;
        logic [15:0] rdata;
        logic        wn;
        logic [15:0] din;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    area_bus_ctrl uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .req              (req),
        .req_addr         (req_addr),
        .req_wr           (req_wr),
        .req_word         (req_word),
        .req_wdata        (req_wdata),
        .rsp_rdata        (rsp_rdata),
        .rsp_done         (rsp_done),
        .cfg_narrow_space (cfg_narrow_space),
        .cfg_wait_pin     (cfg_wait_pin),
        .cfg_wide         (cfg_wide),
        .cfg_three        (cfg_three),
        .cfg_waits        (cfg_waits),
        .bus_addr         (bus_addr),
        .bus_cs_n         (bus_cs_n),
        .bus_rd_n         (bus_rd_n),
        .bus_wrh_n        (bus_wrh_n),
        .bus_wrl_n        (bus_wrl_n),
        .bus_dout         (bus_dout),
        .bus_din          (bus_din),
        .bus_wait_n       (bus_wait_n)
    );

    function automatic exp_t idle_exp();
        exp_t e;
        e = '0;
        e.cs = 8'hFF;
        e.rd = 1'b1;
        e.wh = 1'b1;
        e.wl = 1'b1;
        e.wn = 1'b1;
        return e;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual %h expected %h", cur_tag, what, $time, act, expv);
        end
    endtask

    // Per-clock comparison of every bus output against the model queue.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = idle_exp();
        compared++;
        chk("R2 cs_n", 32'(bus_cs_n), 32'(e.cs));
        chk("R1 addr", 32'(bus_addr), 32'(e.a));
        chk("R4 rd_n", 32'(bus_rd_n), 32'(e.rd));
        chk("R4 wrh_n", 32'(bus_wrh_n), 32'(e.wh));
        chk("R4 wrl_n", 32'(bus_wrl_n), 32'(e.wl));
        chk("R5 dout", 32'(bus_dout), 32'(e.dout));
        chk("R10 done", 32'(rsp_done), 32'(e.done));
        if (e.done && e.chk_rd) chk("R10 rdata", 32'(rsp_rdata), 32'(e.rdata));
    end

    // Applies the model's wait pin and read data for each clock.
    initial begin
        bus_wait_n = 1'b1;
        bus_din = 16'h0000;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bus_wait_n = exp_q[0].wn;
                bus_din = exp_q[0].din;
            end else begin
                bus_wait_n = 1'b1;
                bus_din = 16'h0000;
            end
        end
    end

    // Issues one request and queues the expected bus trace for it.
    // Called right after a rising edge. poke sends a stray req mid-access.
    task automatic txn(input string tag, input logic [23:0] addr, input logic wr,
                       input logic word, input logic [15:0] wdata,
                       input logic [15:0] din0, input logic [15:0] din1,
                       input int hold, input bit poke);
        logic [23:0] eff;
        int area, nw, three, ncyc, last_s;
        logic wide, eff_ctl, hi, lo;
        logic [15:0] ld, rexp;
        exp_t e;
        cur_tag = tag;
        eff = addr;
        if (cfg_narrow_space) eff[23:20] = 4'h0;
        if (word) eff[0] = 1'b0;
        area = cfg_narrow_space ? int'(addr[19:17]) : int'(addr[23:21]);
        wide = cfg_wide[area];
        three = int'(cfg_three[area]);
        nw = int'(cfg_waits[area*2 +: 2]);
        ncyc = (word && !wide) ? 2 : 1;
        eff_ctl = cfg_wait_pin && (nw != 0);
        hi = !wide || word || !eff[0];
        lo = wide && (word || eff[0]);
        last_s = 1 + nw + three;
        exp_q.push_back(idle_exp());
        for (int c = 0; c < ncyc; c++) begin
            if (!wide) ld = {(word && c == 0) ? wdata[15:8] : wdata[7:0], 8'h00};
            else if (word) ld = wdata;
            else if (eff[0]) ld = {8'h00, wdata[7:0]};
            else ld = {wdata[7:0], 8'h00};
            for (int s = 0; s <= last_s; s++) begin
                e = '0;
                e.cs = ~(8'h01 << area);
                e.a = eff | 24'(c);
                e.rd = !(!wr && s != 0);
                e.wh = !(wr && s != 0 && hi);
                e.wl = !(wr && s != 0 && lo);
                e.dout = wr ? ld : 16'h0000;
                e.din = (c == 0) ? din0 : din1;
                e.wn = (hold > 0 && !eff_ctl) ? 1'b0 : 1'b1;
                if (eff_ctl && s == 1 + nw) begin
                    for (int h = 0; h < hold; h++) begin
                        exp_t eh;
                        eh = e;
                        eh.wn = 1'b0;
                        exp_q.push_back(eh);
                    end
                end
                exp_q.push_back(e);
            end
        end
        if (!wide && word) rexp = {din0[15:8], din1[15:8]};
        else if (word) rexp = din0;
        else if (wide && eff[0]) rexp = {8'h00, din0[7:0]};
        else rexp = {8'h00, din0[15:8]};
        e = idle_exp();
        e.done = 1'b1;
        e.chk_rd = !wr;
        e.rdata = rexp;
        exp_q.push_back(e);
        req = 1'b1;
        req_addr = addr;
        req_wr = wr;
        req_word = word;
        req_wdata = wdata;
        @(posedge clk);
        #1;
        req = 1'b0;
        req_addr = 24'hFFFFFF;
        req_wdata = 16'hDEAD;
        if (poke) begin
            @(posedge clk);
            #1;
            req = 1'b1;
            req_addr = 24'hE00002;
            req_wr = !wr;
            req_word = 1'b1;
            @(posedge clk);
            #1;
            req = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        req = 1'b0;
        req_addr = '0;
        req_wr = 1'b0;
        req_word = 1'b0;
        req_wdata = '0;
        cfg_narrow_space = 1'b0;
        cfg_wait_pin = 1'b1;
        cfg_wide = 8'hD5;
        cfg_three = 8'h49;
        cfg_waits = {2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd0, 2'd0};
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R12: read data register cleared by reset
        compared++;
        chk("R12 rdata", 32'(rsp_rdata), 32'h0);
        @(posedge clk);
        #1;

        // R3 R5: word write, 16-bit three-state area 0
        txn("R3", 24'h000100, 1'b1, 1'b1, 16'hA55A, 16'h0, 16'h0, 0, 1'b0);
        // R5: byte reads from both lanes of area 0
        txn("R5", 24'h000102, 1'b0, 1'b0, 16'h0, 16'h1234, 16'h0, 0, 1'b0);
        txn("R5", 24'h000103, 1'b0, 1'b0, 16'h0, 16'h1234, 16'h0, 0, 1'b0);
        // R5: odd byte write to 16-bit area 2 with two waits
        txn("R5", 24'h400031, 1'b1, 1'b0, 16'h0077, 16'h0, 16'h0, 0, 1'b0);
        // R6: split word write and read on 8-bit area 1
        txn("R6", 24'h200010, 1'b1, 1'b1, 16'hBEEF, 16'h0, 16'h0, 0, 1'b0);
        txn("R6", 24'h200010, 1'b0, 1'b1, 16'h0, 16'hAB11, 16'hCD22, 0, 1'b0);
        // R7: word read at odd address runs at even address
        txn("R7", 24'h400011, 1'b0, 1'b1, 16'h0, 16'h5AA5, 16'h0, 0, 1'b0);
        // R8: pin stretches final wait, area 4 (3 waits) and split area 5
        txn("R8", 24'h800040, 1'b0, 1'b1, 16'h0, 16'h3C3C, 16'h0, 2, 1'b0);
        txn("R8", 24'hA00044, 1'b1, 1'b1, 16'h1357, 16'h0, 16'h0, 1, 1'b0);
        // R9: pin ignored when disabled, and when waits are zero
        cfg_wait_pin = 1'b0;
        txn("R9", 24'h800050, 1'b0, 1'b0, 16'h0, 16'h9876, 16'h0, 3, 1'b0);
        cfg_wait_pin = 1'b1;
        txn("R9", 24'hE00060, 1'b1, 1'b1, 16'h2468, 16'h0, 16'h0, 2, 1'b0);
        // R1: narrow space, bits 19:17 pick area 3, upper bits dropped
        cfg_narrow_space = 1'b1;
        txn("R1", 24'hF60004, 1'b1, 1'b0, 16'h00C3, 16'h0, 16'h0, 0, 1'b0);
        txn("R1", 24'h3E0009, 1'b0, 1'b0, 16'h0, 16'h4400, 16'h0, 0, 1'b0);
        cfg_narrow_space = 1'b0;
        // R11: stray request during an area 6 read is dropped
        txn("R11", 24'hC00070, 1'b0, 1'b1, 16'h0, 16'hF00D, 16'h0, 0, 1'b1);
        // R3 R4: three-state write with one wait in area 6
        txn("R4", 24'hC00072, 1'b1, 1'b0, 16'h0066, 16'h0, 16'h0, 0, 1'b0);
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule